// File: doc/BRIEF.md
# Subroutine Call Push Sequencer

This block performs the stack side of a subroutine call for a small 8-bit processor core that has a 16-bit program counter and a byte-wide stack growing toward lower addresses. When a call is started, the block takes the call opcode, the current program counter, the current stack pointer and an effective target address that has already been computed. From the opcode it works out the instruction length and the total cycle count. It adds the length to the program counter to form the return address, then writes that address to memory one byte per cycle.

The low byte of the return address is written first. The stack pointer drops by one after each write. Once both bytes are written, the block presents the target as the new program counter. It raises `done` in the final cycle of the count for that addressing mode. The stack pointer selects a byte within one fixed stack page, and decrements wrap inside that page. An opcode that is not one of the five call encodings is rejected with a one-cycle `illegal` pulse. A rejected opcode causes no memory write.

Top module: `jsr_push_seq`

## Requirements
- R1: After reset, `busy`, `done`, `illegal` and `memWe` are low, and `newPc` and `newSp` are zero.
- R2: The return address is `curPc` plus the instruction length, modulo 2^16. The length is 1 for opcode 0xFD, 2 for 0xBD and 0xED, and 3 for 0xCD and 0xDD.
- R3: In the first cycle after a call is accepted, `memWe` is high, `memAddr` is {STACK_PAGE, `curSp`} and `memWdata` is the low byte of the return address.
- R4: In the second cycle, `memWe` is high, `memAddr` is {STACK_PAGE, `curSp`-1}, with the subtraction wrapping inside the 8-bit page offset, and `memWdata` is the high byte of the return address.
- R5: Once both writes are done, `newSp` equals `curSp`-2 modulo 256.
- R6: In the cycle where `done` is high, `newPc` equals the target address captured at acceptance.
- R7: `busy` is high for exactly N cycles after acceptance, and `done` is high only in the last of them. N is 5 for 0xBD, 6 for 0xCD, 7 for 0xDD, 6 for 0xED and 5 for 0xFD.
- R8: A start with any other opcode gives one `illegal` cycle in the next cycle. It causes no write and leaves `busy`, `newPc` and `newSp` unchanged.
- R9: A start that arrives while `busy` is high is ignored. Inputs applied with it change no write, timing or result of the call in progress.
- R10: Each accepted call makes exactly two memory writes, and `memWe` is never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a call; sampled only while idle |
| opcode | input | 8 | Call opcode that selects the addressing mode |
| targetAddr | input | 16 | Effective subroutine address |
| curPc | input | 16 | Program counter at the call instruction |
| curSp | input | 8 | Stack pointer offset within the stack page |
| busy | output | 1 | Call in progress |
| done | output | 1 | Final cycle of the call |
| illegal | output | 1 | One-cycle pulse for a rejected opcode |
| memWe | output | 1 | Stack byte write enable |
| memAddr | output | 16 | Stack write address |
| memWdata | output | 8 | Stack write data |
| newPc | output | 16 | Program counter after the call |
| newSp | output | 8 | Stack pointer after the pushes |

## Verification
The hardest case to reach from the ports is a start request that arrives while a call is still running, with different opcode, address and stack inputs. The stimulus holds `start` high through the middle of a call. It then checks that the writes, the done cycle and the results all match the first request. The stack and program counter wrap cases are also hard to reach. They are covered by choosing a stack pointer of 0x01 or 0x00 and a program counter near 0xFFFF, so the page offset and the return address roll over during the call.

// File: rtl/jsr_pkg.sv
package jsr_pkg;
  localparam int LEN_W = 2;
  localparam int PH_W  = 3;

  typedef struct packed {
    logic capture;
    logic pushLo;
    logic pushHi;
    logic loadPc;
  } dpCtrl_t;

  typedef struct packed {
    logic            legal;
    logic [LEN_W-1:0] len;
    logic [PH_W-1:0]  lastIdx;
  } callInfo_t;

  function automatic callInfo_t decodeCall(input logic [7:0] op);
    callInfo_t r;
    r.legal = 1'b1;
    case (op)
      8'hBD: begin r.len = 2'd2; r.lastIdx = 3'd4; end
      8'hCD: begin r.len = 2'd3; r.lastIdx = 3'd5; end
      8'hDD: begin r.len = 2'd3; r.lastIdx = 3'd6; end
      8'hED: begin r.len = 2'd2; r.lastIdx = 3'd5; end
      8'hFD: begin r.len = 2'd1; r.lastIdx = 3'd4; end
      default: begin r.legal = 1'b0; r.len = '0; r.lastIdx = '0; end
    endcase
    return r;
  endfunction
endpackage

// File: rtl/jsr_ctrl.sv
module jsr_ctrl
  import jsr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [7:0]       opcode,
  output dpCtrl_t          ctrl,
  output logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic             illegal
);
  typedef enum logic {IDLE, RUN} state_t;
  state_t          state;
  logic [PH_W-1:0] phase;
  logic [PH_W-1:0] lastIdx;
  callInfo_t       info;

  always_comb info = decodeCall(opcode);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= IDLE;
      phase   <= '0;
      lastIdx <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= 1'b0;
      case (state)
        IDLE: if (start) begin
          if (info.legal) begin
            state   <= RUN;
            phase   <= '0;
            lastIdx <= info.lastIdx;
          end else begin
            illegal <= 1'b1;
          end
        end
        RUN: begin
          if (phase == lastIdx) state <= IDLE;
          else phase <= phase + 1'b1;
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_comb begin
    busy         = (state == RUN);
    done         = busy && (phase == lastIdx);
    len          = info.len;
    ctrl.capture = (state == IDLE) && start && info.legal;
    ctrl.pushLo  = busy && (phase == PH_W'(0));
    ctrl.pushHi  = busy && (phase == PH_W'(1));
    ctrl.loadPc  = busy && (phase == lastIdx - 1'b1);
  end

  // R7: done lasts one cycle and ends the call
  assert_single_done_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !busy && !done);
  // R9: once running, a new start cannot restart the phase sequence
  assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy && !done |=> busy);
endmodule

// File: rtl/jsr_datapath.sv
module jsr_datapath
  import jsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 8,
  parameter logic [2*DATA_W-SP_W-1:0] STACK_PAGE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpCtrl_t             ctrl,
  input  logic [LEN_W-1:0]    len,
  input  logic [2*DATA_W-1:0] targetAddr,
  input  logic [2*DATA_W-1:0] curPc,
  input  logic [SP_W-1:0]     curSp,
  output logic                memWe,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [2*DATA_W-1:0] newPc,
  output logic [SP_W-1:0]     newSp
);
  localparam int PC_W = 2 * DATA_W;

  logic [PC_W-1:0] retAddr;
  logic [PC_W-1:0] tgtReg;
  logic [PC_W-1:0] pcReg;
  logic [SP_W-1:0] spReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      retAddr <= '0;
      tgtReg  <= '0;
      pcReg   <= '0;
      spReg   <= '0;
    end else begin
      if (ctrl.capture) begin
        retAddr <= curPc + {{(PC_W-LEN_W){1'b0}}, len};
        tgtReg  <= targetAddr;
        spReg   <= curSp;
      end
      if (ctrl.pushLo || ctrl.pushHi) spReg <= spReg - 1'b1;
      if (ctrl.loadPc) pcReg <= tgtReg;
    end
  end

  always_comb begin
    memWe    = ctrl.pushLo || ctrl.pushHi;
    memAddr  = {STACK_PAGE, spReg};
    memWdata = ctrl.pushLo ? retAddr[DATA_W-1:0]
             : ctrl.pushHi ? retAddr[PC_W-1:DATA_W] : '0;
    newPc    = pcReg;
    newSp    = spReg;
  end
endmodule

// File: rtl/jsr_push_seq.sv
module jsr_push_seq
  import jsr_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SP_W   = 8,
  parameter logic [2*DATA_W-SP_W-1:0] STACK_PAGE = '0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [7:0]          opcode,
  input  logic [2*DATA_W-1:0] targetAddr,
  input  logic [2*DATA_W-1:0] curPc,
  input  logic [SP_W-1:0]     curSp,
  output logic                busy,
  output logic                done,
  output logic                illegal,
  output logic                memWe,
  output logic [2*DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0]   memWdata,
  output logic [2*DATA_W-1:0] newPc,
  output logic [SP_W-1:0]     newSp
);
  dpCtrl_t          ctrl;
  logic [LEN_W-1:0] len;

  jsr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .ctrl(ctrl), .len(len), .busy(busy), .done(done), .illegal(illegal)
  );

  jsr_datapath #(.DATA_W(DATA_W), .SP_W(SP_W), .STACK_PAGE(STACK_PAGE)) uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .len(len),
    .targetAddr(targetAddr), .curPc(curPc), .curSp(curSp),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .newPc(newPc), .newSp(newSp)
  );

  // R10: stack writes happen only inside a call
  assert_we_in_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);
  // R3: the first busy cycle is a write
  assert_first_write_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> memWe);
  // R4: second write goes one byte lower within the page
  assert_hi_below_lo_R4: assert property (@(posedge clk) disable iff (!rstN)
    memWe && $past(memWe) |->
      memAddr[SP_W-1:0] == SP_W'($past(memAddr[SP_W-1:0]) - 1'b1));
  // R8: rejected opcode produces no activity
  assert_illegal_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> !busy && !memWe);
endmodule

// File: tb/sim_jsr_push_seq.sv
`timescale 1ns/1ps
module sim_jsr_push_seq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  opcode = 8'h00;
  logic [15:0] targetAddr = 16'h0, curPc = 16'h0;
  logic [7:0]  curSp = 8'h0;
  logic        busy, done, illegal, memWe;
  logic [15:0] memAddr, newPc;
  logic [7:0]  memWdata, newSp;

  int nChecks = 0;
  int nErr = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  jsr_push_seq u0 (
    .clk(clk), .rstN(rstN), .start(start), .opcode(opcode),
    .targetAddr(targetAddr), .curPc(curPc), .curSp(curSp),
    .busy(busy), .done(done), .illegal(illegal), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .newPc(newPc), .newSp(newSp)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic doCall(input logic [7:0] op, input logic [15:0] pc,
                        input logic [7:0] sp, input logic [15:0] tgt,
                        input int expCyc, input int expLen, input bit midStart);
    logic [15:0] ret;
    int nWr, doneAt, busyBad;
    ret = pc + 16'(expLen);
    nWr = 0; doneAt = 0; busyBad = 0;
    @(negedge clk);
    start = 1'b1; opcode = op; curPc = pc; curSp = sp; targetAddr = tgt;
    @(negedge clk);
    start = 1'b0; opcode = 8'hCD; curPc = ~pc; curSp = sp + 8'h40; targetAddr = ~tgt;
    for (int c = 1; c <= expCyc + 1; c++) begin
      if (c > 1) @(negedge clk);
      if (midStart && c == 2) start = 1'b1;
      if (midStart && c == expCyc) start = 1'b0;
      if (busy != (c <= expCyc)) busyBad++;
      if (memWe) begin
        nWr++;
        if (nWr == 1) begin
          chk(c == 1, "R3", "first write cycle", c, 1);
          chk(memAddr == {8'h00, sp}, "R3", "low push address", memAddr, {8'h00, sp});
          chk(memWdata == ret[7:0], "R2", "low return byte", memWdata, ret[7:0]);
        end else if (nWr == 2) begin
          chk(c == 2, "R4", "second write cycle", c, 2);
          chk(memAddr == {8'h00, sp - 8'h01}, "R4", "high push address",
              memAddr, {8'h00, sp - 8'h01});
          chk(memWdata == ret[15:8], "R4", "high return byte", memWdata, ret[15:8]);
        end
      end
      if (done) begin
        if (doneAt == 0) doneAt = c;
        chk(newPc == tgt, "R6", "newPc at done", newPc, tgt);
        chk(newSp == sp - 8'h02, "R5", "newSp at done", newSp, sp - 8'h02);
      end
    end
    chk(busyBad == 0, "R7", "busy window length", busyBad, 0);
    chk(doneAt == expCyc, "R7", "done cycle", doneAt, expCyc);
    chk(nWr == 2, "R10", "write count", nWr, 2);
    if (midStart) chk(!busy, "R9", "no restart after mid-run start", busy, 0);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk(!busy && !done && !illegal && !memWe, "R1", "reset strobes",
        {busy, done, illegal, memWe}, 0);
    chk(newPc == 16'h0 && newSp == 8'h0, "R1", "reset results", {newPc, newSp}, 0);
  endtask

  task automatic testModes();
    doCall(8'hBD, 16'h1200, 8'hFF, 16'h0040, 5, 2, 0);
    doCall(8'hCD, 16'h3456, 8'hF0, 16'hABCD, 6, 3, 0);
    doCall(8'hDD, 16'h7FF0, 8'h80, 16'h1111, 7, 3, 0);
    doCall(8'hED, 16'h00FE, 8'h33, 16'h2222, 6, 2, 0);
    doCall(8'hFD, 16'h4000, 8'h10, 16'h3333, 5, 1, 0);
  endtask

  task automatic testWraps();
    doCall(8'hFD, 16'h5000, 8'h01, 16'h0100, 5, 1, 0);
    doCall(8'hBD, 16'h6000, 8'h00, 16'h0200, 5, 2, 0);
    doCall(8'hCD, 16'hFFFE, 8'h7F, 16'h0300, 6, 3, 0);
  endtask

  task automatic testMidStart();
    doCall(8'hDD, 16'h2468, 8'hC0, 16'h9999, 7, 3, 1);
  endtask

  task automatic testIllegal();
    logic [15:0] pcBefore;
    logic [7:0] spBefore;
    int wr;
    pcBefore = newPc; spBefore = newSp; wr = 0;
    @(negedge clk);
    start = 1'b1; opcode = 8'hAD; curPc = 16'h1000; curSp = 8'h55; targetAddr = 16'hDEAD;
    @(negedge clk);
    start = 1'b0;
    chk(illegal, "R8", "illegal pulse", illegal, 1);
    chk(!busy, "R8", "no busy on illegal", busy, 0);
    if (memWe) wr++;
    @(negedge clk);
    if (memWe) wr++;
    chk(!illegal, "R8", "illegal pulse length", illegal, 0);
    chk(wr == 0, "R8", "no writes on illegal", wr, 0);
    chk(newPc == pcBefore && newSp == spBefore, "R8", "results unchanged",
        {newPc, newSp}, {pcBefore, spBefore});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testModes();
    testWraps();
    testMidStart();
    testIllegal();
    doCall(8'hED, 16'hA000, 8'h20, 16'hBEEF, 6, 2, 0);
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nErr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErr);
      $finish;
    end
  end
endmodule